// File: doc/BRIEF.md
# Control Byte Transaction Router

This block sits after a serial slave front end that has already matched the device address. The front end hands it one byte per cycle, together with a strobe that opens a transfer and a strobe that closes it. The router reads control bytes out of that byte stream. Each control byte names a destination for the data bytes that follow it: the command register or the display RAM. The router then forwards each data byte as a one-cycle command strobe or as a one-cycle RAM write.

The top bit of each control byte sets the framing. When it is set, one data byte is forwarded and the byte after it is read as a fresh control byte. When it is clear, every byte up to the end of the transfer is data for the chosen destination. Command and RAM traffic can therefore be interleaved within one transfer, or a long burst can be streamed behind a single control byte. RAM writes go to an internal pointer. The pointer advances by one after each write and returns to zero after the last location of the configured depth.

Top module: `ctl_byte_router`

## Requirements
- R1: The first byte accepted after a transfer-start strobe is treated as a control byte and produces no command or RAM strobe.
- R2: A control byte with bit 7 = 1 causes exactly one following data byte to be routed. The byte after that data byte is parsed as a new control byte.
- R3: A control byte with bit 7 = 0 causes every later byte in the transfer to be routed as data to the selected destination.
- R4: Bits 6:5 = 00 select the command register. Each routed byte raises `cmd_valid` for one cycle, with the byte on `cmd_data`, in the cycle after the byte is accepted.
- R5: Bits 6:5 = 01 select display RAM. Each routed byte raises `ram_we` for one cycle, with the byte on `ram_data` and its location on `ram_addr`, in the cycle after the byte is accepted.
- R6: Bits 6:5 = 10 or 11 cause the data bytes that follow to be discarded. No strobe is produced and the RAM pointer does not move.
- R7: Bits 4:0 of a control byte have no effect on routing.
- R8: Successive RAM writes use consecutive addresses starting from 0 after reset. After address RAM_DEPTH-1 the next write goes to address 0.
- R9: A transfer-start or transfer-end strobe returns the router to expecting a control byte. A byte presented in the same cycle as either strobe is dropped.
- R10: A transfer that ends directly after a control byte produces no strobe.
- R11: During and after reset, both strobes are low and `ram_addr` is 0. `cmd_valid` and `ram_we` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | Transfer opened (address phase matched) |
| xfer_end | input | 1 | Transfer closed |
| byte_valid | input | 1 | A received byte is on `byte_data` this cycle |
| byte_data | input | 8 | Received byte |
| cmd_valid | output | 1 | One-cycle strobe for a routed command byte |
| cmd_data | output | 8 | Command byte |
| ram_we | output | 1 | One-cycle display RAM write strobe |
| ram_addr | output | ADDR_W | Location of the current RAM write |
| ram_data | output | 8 | RAM write data |

## Verification
The bench builds the router with RAM_DEPTH = 6. This is not a power of two, so it selects the compare-and-clear wrap variant of the pointer, and a seven-byte burst is enough to drive the pointer past its last location and back to 0. The small depth also makes it possible to confirm that discarded bytes and aborted transfers leave the pointer in place, by looking at the address of the next real write.

// File: rtl/ctl_router_pkg.sv
package ctl_router_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        WAIT_CTRL = 2'd0,
        ONE_DATA  = 2'd1,
        ALL_DATA  = 2'd2
    } frame_st_e;

    typedef enum logic [1:0] {
        DEST_CMD  = 2'd0,
        DEST_RAM  = 2'd1,
        DEST_NONE = 2'd2
    } dest_e;

    typedef struct packed {
        logic       more;
        logic [1:0] sel;
        logic [4:0] spare;
    } ctrl_byte_t;

    typedef struct packed {
        logic              to_cmd;
        logic              to_ram;
        logic [BYTE_W-1:0] data;
    } route_t;

    function automatic dest_e sel_to_dest(input logic [1:0] sel);
        case (sel)
            2'b00:   return DEST_CMD;
            2'b01:   return DEST_RAM;
            default: return DEST_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ctl_frame_parser.sv
module ctl_frame_parser
    import ctl_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_start,
    input  logic              xfer_end,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output route_t            route
);

    frame_st_e  state_q, state_d;
    dest_e      dest_q, dest_d;
    ctrl_byte_t ctl;
    logic       take;
    logic       unused_spare;

    assign ctl          = ctrl_byte_t'(byte_data);
    assign unused_spare = ^ctl.spare;
    assign take         = byte_valid && !xfer_start && !xfer_end;

    always_comb begin
        state_d = state_q;
        dest_d  = dest_q;
        if (xfer_start || xfer_end) begin
            state_d = WAIT_CTRL;
        end else if (byte_valid) begin
            case (state_q)
                WAIT_CTRL: begin
                    dest_d  = sel_to_dest(ctl.sel);
                    state_d = ctl.more ? ONE_DATA : ALL_DATA;
                end
                ONE_DATA: state_d = WAIT_CTRL;
                default:  state_d = ALL_DATA;
            endcase
        end
    end

    always_comb begin
        route.data   = byte_data;
        route.to_cmd = take && (state_q != WAIT_CTRL) && (dest_q == DEST_CMD);
        route.to_ram = take && (state_q != WAIT_CTRL) && (dest_q == DEST_RAM);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WAIT_CTRL;
            dest_q  <= DEST_NONE;
        end else begin
            state_q <= state_d;
            dest_q  <= dest_d;
        end
    end

endmodule

// File: rtl/ram_ptr_gen.sv
module ram_ptr_gen #(
    parameter int RAM_DEPTH = 44,
    parameter int ADDR_W    = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [ADDR_W-1:0] ptr
);

    localparam bit IS_POW2 = (RAM_DEPTH & (RAM_DEPTH - 1)) == 0;
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(RAM_DEPTH - 1);

    logic [ADDR_W-1:0] nxt;

    generate
        if (IS_POW2) begin : g_natural_wrap
            assign nxt = ptr + 1'b1;
        end else begin : g_compare_wrap
            assign nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)      ptr <= '0;
        else if (adv) ptr <= nxt;
    end

endmodule

// File: rtl/route_out_stage.sv
module route_out_stage
    import ctl_router_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  route_t            route,
    input  logic [ADDR_W-1:0] ptr,
    output logic              cmd_valid,
    output logic [BYTE_W-1:0] cmd_data,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [BYTE_W-1:0] ram_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid <= 1'b0;
            cmd_data  <= '0;
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_data  <= '0;
        end else begin
            cmd_valid <= route.to_cmd;
            ram_we    <= route.to_ram;
            if (route.to_cmd) cmd_data <= route.data;
            if (route.to_ram) begin
                ram_data <= route.data;
                ram_addr <= ptr;
            end
        end
    end

endmodule

// File: rtl/ctl_byte_router.sv
module ctl_byte_router
    import ctl_router_pkg::*;
#(
    parameter int RAM_DEPTH = 44,
    parameter int ADDR_W    = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_start,
    input  logic              xfer_end,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    output logic              cmd_valid,
    output logic [7:0]        cmd_data,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_data
);

    route_t            route;
    logic [ADDR_W-1:0] ptr;

    ctl_frame_parser u_parser (
        .clk        (clk),
        .rst        (rst),
        .xfer_start (xfer_start),
        .xfer_end   (xfer_end),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .route      (route)
    );

    ram_ptr_gen #(
        .RAM_DEPTH (RAM_DEPTH),
        .ADDR_W    (ADDR_W)
    ) u_ptr (
        .clk (clk),
        .rst (rst),
        .adv (route.to_ram),
        .ptr (ptr)
    );

    route_out_stage #(
        .ADDR_W (ADDR_W)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .route     (route),
        .ptr       (ptr),
        .cmd_valid (cmd_valid),
        .cmd_data  (cmd_data),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_data  (ram_data)
    );

endmodule

// File: rtl/ctl_byte_router_chk.sv
module ctl_byte_router_chk #(
    parameter int RAM_DEPTH = 44,
    parameter int ADDR_W    = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              xfer_start,
    input logic              xfer_end,
    input logic              byte_valid,
    input logic [7:0]        byte_data,
    input logic              cmd_valid,
    input logic [7:0]        cmd_data,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [7:0]        ram_data
);

    logic [ADDR_W-1:0] last_addr;
    logic [ADDR_W-1:0] want_addr;
    logic              seen_write;
    logic              unused_sigs;

    assign unused_sigs = xfer_start ^ (^ram_data);
    assign want_addr = (last_addr == ADDR_W'(RAM_DEPTH - 1)) ? '0 : last_addr + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_addr  <= '0;
            seen_write <= 1'b0;
        end else if (ram_we) begin
            last_addr  <= ram_addr;
            seen_write <= 1'b1;
        end
    end

    // R11: the two strobes never coincide
    p_one_dest_r11: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && ram_we));

    // R9 / R10: nothing is routed from the cycle that closes a transfer
    p_end_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        xfer_end |=> (!cmd_valid && !ram_we));

    // R4: command strobe carries the byte accepted one cycle earlier
    p_cmd_payload_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> ($past(byte_valid) && cmd_data == $past(byte_data)));

    // R8: consecutive writes use consecutive, wrapping locations
    p_addr_step_r8: assert property (@(posedge clk) disable iff (rst)
        (ram_we && seen_write) |-> (ram_addr == want_addr));

    // R8: address never leaves the configured depth
    p_addr_range_r8: assert property (@(posedge clk) disable iff (rst)
        ram_addr <= ADDR_W'(RAM_DEPTH - 1));

endmodule

bind ctl_byte_router ctl_byte_router_chk #(
    .RAM_DEPTH (RAM_DEPTH),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .xfer_start (xfer_start),
    .xfer_end   (xfer_end),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .cmd_valid  (cmd_valid),
    .cmd_data   (cmd_data),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_data   (ram_data)
);

// File: tb/ctl_byte_router_test.sv
module ctl_byte_router_test;

    localparam int DEPTH = 6;
    localparam int AW    = 3;

    typedef struct packed {
        logic       st;
        logic       en;
        logic       v;
        logic [7:0] d;
        logic       ec;
        logic       ew;
        logic [2:0] ea;
        logic [7:0] rq;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 3'd0, 8'd1 },  // R1 open
        '{1'b0, 1'b0, 1'b1, 8'h80, 1'b0, 1'b0, 3'd0, 8'd1 },  // R1 control, more, cmd
        '{1'b0, 1'b0, 1'b1, 8'h3C, 1'b1, 1'b0, 3'd0, 8'd4 },  // R4 command
        '{1'b0, 1'b0, 1'b1, 8'hA0, 1'b0, 1'b0, 3'd0, 8'd2 },  // R2 next byte is control
        '{1'b0, 1'b0, 1'b1, 8'h11, 1'b0, 1'b1, 3'd0, 8'd5 },  // R5 ram write at 0
        '{1'b0, 1'b0, 1'b1, 8'h1F, 1'b0, 1'b0, 3'd0, 8'd2 },  // R2 R7 control, last, cmd
        '{1'b0, 1'b0, 1'b1, 8'h55, 1'b1, 1'b0, 3'd0, 8'd3 },  // R3 stream cmd
        '{1'b0, 1'b0, 1'b1, 8'h66, 1'b1, 1'b0, 3'd0, 8'd3 },  // R3 stream cmd
        '{1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 3'd0, 8'd9 },  // R9 close
        '{1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 3'd0, 8'd1 },
        '{1'b0, 1'b0, 1'b1, 8'h3F, 1'b0, 1'b0, 3'd0, 8'd7 },  // R7 last, ram, spare bits set
        '{1'b0, 1'b0, 1'b1, 8'h01, 1'b0, 1'b1, 3'd1, 8'd3 },  // R3 burst
        '{1'b0, 1'b0, 1'b1, 8'h02, 1'b0, 1'b1, 3'd2, 8'd3 },
        '{1'b0, 1'b0, 1'b1, 8'h03, 1'b0, 1'b1, 3'd3, 8'd8 },
        '{1'b0, 1'b0, 1'b1, 8'h04, 1'b0, 1'b1, 3'd4, 8'd8 },
        '{1'b0, 1'b0, 1'b1, 8'h05, 1'b0, 1'b1, 3'd5, 8'd8 },
        '{1'b0, 1'b0, 1'b1, 8'h06, 1'b0, 1'b1, 3'd0, 8'd8 },  // R8 wrap
        '{1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 3'd0, 8'd9 },
        '{1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 3'd0, 8'd1 },
        '{1'b0, 1'b0, 1'b1, 8'hC0, 1'b0, 1'b0, 3'd0, 8'd6 },  // R6 sel 10
        '{1'b0, 1'b0, 1'b1, 8'h77, 1'b0, 1'b0, 3'd0, 8'd6 },  // R6 dropped
        '{1'b0, 1'b0, 1'b1, 8'hE5, 1'b0, 1'b0, 3'd0, 8'd6 },  // R6 sel 11
        '{1'b0, 1'b0, 1'b1, 8'h88, 1'b0, 1'b0, 3'd0, 8'd6 },  // R6 dropped
        '{1'b0, 1'b0, 1'b1, 8'h20, 1'b0, 1'b0, 3'd0, 8'd5 },
        '{1'b0, 1'b0, 1'b1, 8'h99, 1'b0, 1'b1, 3'd1, 8'd6 },  // R6 pointer unmoved
        '{1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 3'd0, 8'd9 }
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          xfer_start = 1'b0;
    logic          xfer_end = 1'b0;
    logic          byte_valid = 1'b0;
    logic [7:0]    byte_data = '0;
    logic          cmd_valid;
    logic [7:0]    cmd_data;
    logic          ram_we;
    logic [AW-1:0] ram_addr;
    logic [7:0]    ram_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ctl_byte_router #(.RAM_DEPTH(DEPTH)) uut (
        .clk        (clk),
        .rst        (rst),
        .xfer_start (xfer_start),
        .xfer_end   (xfer_end),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .cmd_valid  (cmd_valid),
        .cmd_data   (cmd_data),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_data   (ram_data)
    );

    task automatic check(input string req, input logic ec, input logic ew,
                         input logic [2:0] ea, input logic [7:0] ed);
        logic ok;
        checks++;
        ok = (cmd_valid === ec) && (ram_we === ew) && !(cmd_valid && ram_we)
             && (!ec || cmd_data === ed)
             && (!ew || (ram_data === ed && ram_addr === ea));
        if (!ok) begin
            fails++;
            $display("FAIL %s: got cmd=%b/%h we=%b addr=%0d data=%h, expected cmd=%b we=%b addr=%0d data=%h",
                     req, cmd_valid, cmd_data, ram_we, ram_addr, ram_data, ec, ew, ea, ed);
        end
    endtask

    task automatic step(input logic st, input logic en, input logic v, input logic [7:0] d,
                        input logic ec, input logic ew, input logic [2:0] ea, input string req);
        xfer_start = st;
        xfer_end   = en;
        byte_valid = v;
        byte_data  = d;
        @(negedge clk);
        check(req, ec, ew, ea, d);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R11: reset state
        checks++;
        if (cmd_valid !== 1'b0 || ram_we !== 1'b0 || ram_addr !== '0) begin
            fails++;
            $display("FAIL R11: got cmd=%b we=%b addr=%0d, expected 0 0 0", cmd_valid, ram_we, ram_addr);
        end
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].st, VEC[i].en, VEC[i].v, VEC[i].d,
                 VEC[i].ec, VEC[i].ew, VEC[i].ea, $sformatf("R%0d vec%0d", VEC[i].rq, i));
        end

        // R10: transfer ends directly after a control byte
        step(1, 0, 0, 8'h00, 0, 0, 3'd0, "R10 open");
        step(0, 0, 1, 8'h20, 0, 0, 3'd0, "R10 control");
        step(0, 1, 0, 8'h00, 0, 0, 3'd0, "R10 close");
        step(0, 0, 0, 8'h00, 0, 0, 3'd0, "R10 idle");
        step(1, 0, 0, 8'h00, 0, 0, 3'd0, "R10 reopen");
        step(0, 0, 1, 8'h20, 0, 0, 3'd0, "R10 control");
        step(0, 0, 1, 8'h42, 0, 1, 3'd2, "R10 pointer kept");

        // R9: start in mid-stream with a byte in the same cycle
        step(1, 0, 1, 8'hAA, 0, 0, 3'd0, "R9 start drops byte");
        step(0, 0, 1, 8'h9A, 0, 0, 3'd0, "R9 parsed as control");
        step(0, 0, 1, 8'h5A, 1, 0, 3'd0, "R9 command after restart");
        step(0, 0, 1, 8'h77, 0, 0, 3'd0, "R9 control sel 11");
        step(0, 0, 1, 8'h12, 0, 0, 3'd0, "R6 discarded");
        step(0, 1, 0, 8'h00, 0, 0, 3'd0, "R9 close");

        // R9: end strobe with a byte in the same cycle
        step(1, 0, 0, 8'h00, 0, 0, 3'd0, "R9 open");
        step(0, 0, 1, 8'h20, 0, 0, 3'd0, "R9 control ram");
        step(0, 1, 1, 8'h33, 0, 0, 3'd0, "R9 end drops byte");
        step(1, 0, 0, 8'h00, 0, 0, 3'd0, "R9 reopen");
        step(0, 0, 1, 8'h20, 0, 0, 3'd0, "R9 control ram");
        step(0, 0, 1, 8'h44, 0, 1, 3'd3, "R9 pointer kept");
        step(0, 1, 0, 8'h00, 0, 0, 3'd0, "R9 close");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule